// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Bus-Hold Sequencer

This block runs the bus handshake of a four-channel fly-by DMA engine. Each channel has a request line plus three qualifiers: mask, armed and cascade. Each channel also has a direction bit and a last-transfer flag. The block picks one qualified channel by fixed priority and raises a hold request to the processor. Once the hold acknowledge returns, it sequences one transfer for the picked channel. Data never passes through the block. It only drives the strobes, the address enable and the channel acknowledge, and the peripheral and memory exchange data directly on the bus.

A transfer starts with a setup cycle. In that cycle the address and strobe enables are on and the read/write strobe pair for the direction is asserted. The channel acknowledge is added in the following cycle and held for as long as READY is low. One cycle with the strobes negated follows. In that cycle the sequencer either starts the next qualified channel without giving up the bus, or floats the bus for one cycle and then drops the hold request. A channel in cascade mode receives only its acknowledge, and the bus is kept until that channel withdraws its request. Tri-state outputs are modelled as a drive value plus an enable. The address itself comes from outside, selected by the `sel_chan` output.

Top module: `dma_hold_arb`

## Requirements
- R1: After reset, hold_req, addr_oe, strobe_oe, all four strobes, chan_ack and eop are 0.
- R2: A channel qualifies only when chan_req=1, chan_mask=0 and chan_armed=1 for it. While no channel qualifies from idle, hold_req stays 0.
- R3: Among qualified channels the lowest index wins (channel 0 highest). The winner is sampled in the cycle the grant is taken and is shown on sel_chan.
- R4: The hold_req output rises in the cycle after a channel first qualifies and stays high while hold_ack is low. No enable, strobe or acknowledge is driven before a clock edge with hold_ack=1 has been seen.
- R5: The first driven cycle of a transfer has addr_oe=1, strobe_oe=1 and the strobe pair asserted with chan_ack=0. chan_ack bit sel_chan is added in the next cycle.
- R6: With chan_dir=1 (I/O to memory) io_rd and mem_wr are asserted. With chan_dir=0 (memory to I/O) mem_rd and io_wr are asserted. The other two strobes stay 0.
- R7: While READY is low in an acknowledge cycle, the strobes and the acknowledge are held. The cycle after the first edge with ready=1 has the strobes and chan_ack at 0.
- R8: In that post-transfer cycle the enables stay on. If any channel qualifies then, the next grant is taken at once and hold_req does not fall.
- R9: If none qualifies, one cycle follows with both enables at 0 and hold_req at 1, and then hold_req falls.
- R10: A granted channel with chan_cascade=1 gets only its acknowledge. The enables, strobes and eop stay 0 until the channel's chan_req is 0 at a clock edge.
- R11: eop equals chan_last of the selected channel during transfer-acknowledge cycles and is 0 otherwise.
- R12: At most one chan_ack bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | 4 | Per-channel transfer request |
| chan_mask | input | 4 | Per-channel mask, 1 blocks the channel |
| chan_armed | input | 4 | Per-channel programmed flag |
| chan_cascade | input | 4 | Per-channel cascade mode |
| chan_dir | input | 4 | Per-channel direction, 1 = I/O to memory |
| chan_last | input | 4 | Per-channel flag: the coming transfer is the final one |
| hold_ack | input | 1 | Bus granted by processor |
| ready | input | 1 | 0 stretches the acknowledge cycle |
| hold_req | output | 1 | Bus request to processor |
| sel_chan | output | 2 | Index of the granted channel |
| addr_oe | output | 1 | Address drive enable |
| strobe_oe | output | 1 | Strobe drive enable |
| mem_rd | output | 1 | Memory read strobe value |
| mem_wr | output | 1 | Memory write strobe value |
| io_rd | output | 1 | I/O read strobe value |
| io_wr | output | 1 | I/O write strobe value |
| chan_ack | output | 4 | Per-channel acknowledge |
| eop | output | 1 | Shared end-of-process |

## Verification
Several properties are checked on every cycle: a single acknowledge, no drive outside a bus hold, legal strobe pairs, a frozen acknowledge cycle while READY is low, and bus floating before the hold request falls. The silence of cascade grants and an acknowledge-free first transfer cycle are checked the same way. Priority choice, the exact cycle of each handover, back-to-back grants without losing the bus, and rejection of masked or unprogrammed channels are shown only by the bench scenarios compared against its reference model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_SETUP, ST_STROBE, ST_CASC, ST_END, ST_REL
  } arb_state_e;

  // Strobe pattern {mem_rd, mem_wr, io_rd, io_wr} for one direction
  function automatic logic [3:0] strobe_pattern(input logic io_to_mem);
    return io_to_mem ? 4'b0110 : 4'b1001;
  endfunction
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] elig,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = W'(i);
    end
  end
  assign any = |elig;
endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
  import dma_arb_pkg::*;
(
  input  logic active,
  input  logic io_to_mem,
  output logic mem_rd,
  output logic mem_wr,
  output logic io_rd,
  output logic io_wr
);
  logic [3:0] pat;
  assign pat = active ? strobe_pattern(io_to_mem) : 4'b0000;
  assign {mem_rd, mem_wr, io_rd, io_wr} = pat;
endmodule

// File: rtl/dma_hold_arb.sv
module dma_hold_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] chan_armed,
  input  logic [NCH-1:0] chan_cascade,
  input  logic [NCH-1:0] chan_dir,
  input  logic [NCH-1:0] chan_last,
  input  logic           hold_ack,
  input  logic           ready,
  output logic           hold_req,
  output logic [CW-1:0]  sel_chan,
  output logic           addr_oe,
  output logic           strobe_oe,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic [NCH-1:0] chan_ack,
  output logic           eop
);
  arb_state_e st, st_nxt;
  logic [NCH-1:0] elig;
  logic           any_elig;
  logic [CW-1:0]  win_idx;
  logic [CW-1:0]  sel_q;
  logic           dir_q, casc_q;
  logic           grant_now, xfer_phase, ack_phase;

  assign elig = chan_req & ~chan_mask & chan_armed;

  dma_prio_pick #(.N(NCH)) u_pick (
    .elig (elig),
    .any  (any_elig),
    .idx  (win_idx)
  );

  assign grant_now = ((st == ST_HOLD) && hold_ack && any_elig) ||
                     ((st == ST_END) && any_elig);

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:   if (any_elig) st_nxt = ST_HOLD;
      ST_HOLD:   if (hold_ack) st_nxt = !any_elig ? ST_REL :
                                         (chan_cascade[win_idx] ? ST_CASC : ST_SETUP);
      ST_SETUP:  st_nxt = ST_STROBE;
      ST_STROBE: if (ready) st_nxt = ST_END;
      ST_CASC:   if (!chan_req[sel_q]) st_nxt = ST_END;
      ST_END:    st_nxt = !any_elig ? ST_REL :
                          (chan_cascade[win_idx] ? ST_CASC : ST_SETUP);
      ST_REL:    st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sel_q  <= '0;
      dir_q  <= 1'b0;
      casc_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (grant_now) begin
        sel_q  <= win_idx;
        dir_q  <= chan_dir[win_idx];
        casc_q <= chan_cascade[win_idx];
      end
    end
  end

  assign xfer_phase = (st == ST_SETUP) || (st == ST_STROBE);
  assign ack_phase  = (st == ST_STROBE) || (st == ST_CASC);
  assign hold_req   = (st != ST_IDLE);
  assign addr_oe    = xfer_phase || ((st == ST_END) && !casc_q);
  assign strobe_oe  = addr_oe;
  assign sel_chan   = sel_q;
  assign eop        = (st == ST_STROBE) && chan_last[sel_q];

  dma_strobe_dec u_dec (
    .active    (xfer_phase),
    .io_to_mem (dir_q),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ack
    assign chan_ack[g] = ack_phase && (sel_q == CW'(g));
  end

  // ---------------- assertions ----------------
  p_ack_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack));

  p_drive_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe || strobe_oe || (|chan_ack)) |-> hold_req);

  p_strobe_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |->
      (strobe_oe && $countones({mem_rd, mem_wr, io_rd, io_wr}) == 2 &&
       (mem_rd != mem_wr) && (io_rd != io_wr)));

  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_ack) && strobe_oe && !ready) |=>
      ($stable(chan_ack) && $stable({mem_rd, mem_wr, io_rd, io_wr})));

  p_float_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> $past(!addr_oe && !strobe_oe));

  p_cascade_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_ack) && !strobe_oe) |-> (!addr_oe && !eop &&
      !(mem_rd || mem_wr || io_rd || io_wr)));

  p_setup_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_oe) |-> (chan_ack == '0));
endmodule

// File: tb/dma_hold_arb_tb.sv
module dma_hold_arb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] chan_req = '0, chan_mask = '0, chan_armed = '0;
  logic [3:0] chan_cascade = '0, chan_dir = '0, chan_last = '0;
  logic hold_ack = 1'b0, ready = 1'b1;
  logic hold_req, addr_oe, strobe_oe, mem_rd, mem_wr, io_rd, io_wr, eop;
  logic [1:0] sel_chan;
  logic [3:0] chan_ack;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit fast_ack = 1;

  // reference model state: 0 idle,1 hold,2 setup,3 strobe,4 casc,5 end,6 rel
  int m_st = 0, m_sel = 0;
  bit m_dir = 0, m_casc = 0;

  always #2.5 clk = ~clk;

  dma_hold_arb u_dut (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_mask(chan_mask),
    .chan_armed(chan_armed), .chan_cascade(chan_cascade), .chan_dir(chan_dir),
    .chan_last(chan_last), .hold_ack(hold_ack), .ready(ready),
    .hold_req(hold_req), .sel_chan(sel_chan), .addr_oe(addr_oe),
    .strobe_oe(strobe_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .chan_ack(chan_ack), .eop(eop)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  // expected outputs from requirements
  function automatic logic [3:0] exp_strobes(input int st, input bit dir);
    if (st != 2 && st != 3) return 4'b0000;
    return dir ? 4'b0110 : 4'b1001;   // {mem_rd,mem_wr,io_rd,io_wr}
  endfunction

  task automatic compare_all();
    bit e_oe;
    logic [3:0] e_ack;
    e_oe  = (m_st == 2) || (m_st == 3) || (m_st == 5 && !m_casc);
    e_ack = (m_st == 3 || m_st == 4) ? (4'b1 << m_sel) : 4'b0;
    check(hold_req == (m_st != 0), "R4 R9 hold_req", hold_req, m_st != 0);
    check(addr_oe == e_oe, "R5 R8 R10 addr_oe", addr_oe, e_oe);
    check(strobe_oe == e_oe, "R5 R9 strobe_oe", strobe_oe, e_oe);
    check({mem_rd, mem_wr, io_rd, io_wr} == exp_strobes(m_st, m_dir),
          "R6 strobes", {mem_rd, mem_wr, io_rd, io_wr}, exp_strobes(m_st, m_dir));
    check(chan_ack == e_ack, "R7 R12 chan_ack", chan_ack, e_ack);
    check(eop == (m_st == 3 && chan_last[m_sel]), "R11 eop", eop,
          m_st == 3 && chan_last[m_sel]);
    if (m_st >= 2) check(sel_chan == 2'(m_sel), "R3 sel_chan", sel_chan, m_sel);
  endtask

  task automatic model_step();
    logic [3:0] el;
    int w;
    el = chan_req & ~chan_mask & chan_armed;
    w  = lowest(el);
    case (m_st)
      0: if (w >= 0) m_st = 1;
      1: if (hold_ack) begin
           if (w < 0) m_st = 6;
           else begin
             m_sel = w; m_dir = chan_dir[w]; m_casc = chan_cascade[w];
             m_st = m_casc ? 4 : 2;
           end
         end
      2: m_st = 3;
      3: if (ready) m_st = 5;
      4: if (!chan_req[m_sel]) m_st = 5;
      5: begin
           if (w < 0) m_st = 6;
           else begin
             m_sel = w; m_dir = chan_dir[w]; m_casc = chan_cascade[w];
             m_st = m_casc ? 4 : 2;
           end
         end
      default: m_st = 0;
    endcase
  endtask

  // one cycle: set inputs after negedge, compare, advance model
  task automatic step(input logic [3:0] rq, input logic [3:0] mk, input logic [3:0] ar,
                      input logic [3:0] cs, input logic [3:0] dr, input logic [3:0] ls,
                      input logic rdy);
    @(negedge clk);
    if (!hold_req) hold_ack = 1'b0;
    else if (!hold_ack && (fast_ack || ($urandom % 3 == 0))) hold_ack = 1'b1;
    chan_req = rq; chan_mask = mk; chan_armed = ar;
    chan_cascade = cs; chan_dir = dr; chan_last = ls; ready = rdy;
    #1;
    compare_all();
    model_step();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!hold_req && !addr_oe && !strobe_oe && chan_ack == 0 && !eop &&
          {mem_rd, mem_wr, io_rd, io_wr} == 0, "R1 reset outputs",
          {hold_req, addr_oe, strobe_oe, chan_ack, eop}, 0);
    rst_n = 1'b1;

    // R2: masked or unprogrammed requests are ignored
    for (int i = 0; i < 6; i++) begin
      step(4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1);
      check(!hold_req, "R2 masked no hold", hold_req, 0);
    end
    for (int i = 0; i < 6; i++) begin
      step(4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
      check(!hold_req, "R2 unarmed no hold", hold_req, 0);
    end

    // R3 R8: channels 1 and 3 pending, 1 wins, then 3 back-to-back
    step(4'b1010, 4'h0, 4'hF, 4'h0, 4'b0010, 4'h0, 1'b1); // idle -> hold
    step(4'b1010, 4'h0, 4'hF, 4'h0, 4'b0010, 4'h0, 1'b1); // hold, ack arrives
    step(4'b1010, 4'h0, 4'hF, 4'h0, 4'b0010, 4'h0, 1'b1); // setup ch1
    check(sel_chan == 1 && addr_oe && chan_ack == 0, "R3 R5 setup ch1", sel_chan, 1);
    check(io_rd && mem_wr && !mem_rd && !io_wr, "R6 io to mem",
          {mem_rd, mem_wr, io_rd, io_wr}, 4'b0110);
    // R7: stretch two cycles
    step(4'b1000, 4'h0, 4'hF, 4'h0, 4'b0010, 4'b0010, 1'b0);
    check(chan_ack == 4'b0010 && eop, "R7 R11 ack ch1 with eop", {chan_ack, eop}, 5'b00101);
    step(4'b1000, 4'h0, 4'hF, 4'h0, 4'b0010, 4'b0010, 1'b0);
    check(chan_ack == 4'b0010, "R7 held ack", chan_ack, 4'b0010);
    step(4'b1000, 4'h0, 4'hF, 4'h0, 4'b0010, 4'h0, 1'b1);
    step(4'b1000, 4'h0, 4'hF, 4'h0, 4'b0000, 4'h0, 1'b1); // end cycle, ch3 pending
    check(hold_req && addr_oe && chan_ack == 0, "R8 end cycle keeps bus", addr_oe, 1);
    step(4'b0000, 4'h0, 4'hF, 4'h0, 4'b0000, 4'h0, 1'b1); // setup ch3
    check(sel_chan == 3 && hold_req && mem_rd && io_wr, "R8 R6 back-to-back ch3",
          sel_chan, 3);
    step(4'b0000, 4'h0, 4'hF, 4'h0, 4'b0000, 4'h0, 1'b1); // strobe
    step(4'b0000, 4'h0, 4'hF, 4'h0, 4'b0000, 4'h0, 1'b1); // end
    step(4'b0000, 4'h0, 4'hF, 4'h0, 4'b0000, 4'h0, 1'b1); // rel
    check(hold_req && !addr_oe && !strobe_oe, "R9 float before release", addr_oe, 0);
    step(4'b0000, 4'h0, 4'hF, 4'h0, 4'b0000, 4'h0, 1'b1);
    check(!hold_req, "R9 hold dropped", hold_req, 0);

    // R10: cascade channel 2
    for (int i = 0; i < 6; i++) begin
      step(4'b0100, 4'h0, 4'hF, 4'b0100, 4'h0, 4'hF, 1'b1);
      if (i >= 2) check(chan_ack == 4'b0100 && !addr_oe && !eop, "R10 cascade ack only",
                        {chan_ack, addr_oe, eop}, 6'b010000);
    end
    for (int i = 0; i < 4; i++) step(4'h0, 4'h0, 4'hF, 4'b0100, 4'h0, 4'h0, 1'b1);
    check(!hold_req, "R10 cascade released", hold_req, 0);

    // R4: slow acknowledge, random mix
    fast_ack = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rq, mk, ar;
      rq = 4'($urandom);
      mk = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      ar = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
      step(rq, mk, ar, ($urandom % 3 == 0) ? 4'($urandom) : 4'h0, 4'($urandom),
           4'($urandom), ($urandom % 4) != 0);
    end
    for (int i = 0; i < 12; i++) step(4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1);
    check(!hold_req, "R9 idle at end", hold_req, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule